// File: doc/BRIEF.md
# Two-Bank Bitmap Interrupt Controller

This block gathers up to 32 synchronous interrupt lines and presents them to a processor through two independent banks. The first bank drives the normal interrupt request and the second drives the fast interrupt request. Both banks see the same lines, but each bank has its own pending bits, its own enable mask and its own request output. In every set-oriented register, bit n stands for line n.

Software talks to the block over a plain 32-bit register bus. The bus has separate read and write strobes and one address. Read data appears one cycle after the read strobe.

- Enable bits are changed only through two addresses: one sets bits and the other clears them. Both addresses read back the enable mask.
- Pending bits are cleared by writing a bitmap of the lines to acknowledge.
- Each bank reports the lowest-numbered line that is both pending and enabled.

The second bank repeats the first bank's layout at an offset of 0x100.

Top module: `bic_ctrl`

## Requirements
- R1: A rising edge on line n sets pending bit n of both banks on the next clock. The bit stays set while the line stays high, and it stays set after the line falls. A line held high does not set its bit again once the bit has been acknowledged.
- R2: Writing a bitmap to bank offset 0x04 clears the pending bits whose data bits are 1. All other pending bits keep their value. Reading offset 0x04 returns the pending bits.
- R3: When a rising edge on line n and an acknowledge of bit n fall in the same cycle, pending bit n ends up set.
- R4: Writing offset 0x08 sets the enable bits whose data bits are 1 and leaves the others unchanged. Reading 0x08 returns the enable mask.
- R5: Writing offset 0x0C clears the enable bits whose data bits are 1. Reading 0x0C returns the same enable mask as 0x08.
- R6: Offset 0x00 reads pending AND enable. The bank's request output (irq_o for bank 0, fiq_o for bank 1) is high exactly when that value is nonzero.
- R7: Offset 0x24 reads the index of the lowest-numbered bit that is both pending and enabled. It reads the line count (32) when no such bit exists.
- R8: Bank 1 occupies offsets 0x100, 0x104, 0x108, 0x10C and 0x124. Its pending bits and enable mask are separate from bank 0's, and accesses to one bank never change the other.
- R9: A read of any address outside the ten mapped offsets returns zero. A write to such an address changes nothing. Writes to the read-only offsets 0x00 and 0x24 are also ignored.
- R10: After reset, all pending bits and enable bits are zero, both request outputs are low, and both current-number registers read 32.
- R11: bus_rdata takes the addressed value at the clock edge that samples bus_rd high. It holds that value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines, synchronous to clk, rising-edge sensitive |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Bank 0 request |
| fiq_o | output | 1 | Bank 1 request |

## Verification
The bench builds the block with its defaults: NUM_SRC = 32 and ADDR_W = 12. With these values the top line, 31, can be both pending and the reported number, and the "nothing pending" code of 32 sits one above the last valid index.

The 12-bit address leaves room for a bank-select bit and for an address above both banks. This lets the bench show that unmapped writes have no effect and that the two banks stay independent. It also drives a rising edge and an acknowledge of the same line in one cycle.

// File: rtl/bic_pkg.sv
package bic_pkg;

  localparam int NBANK = 2;
  localparam int BUS_W = 32;

  // Register offsets inside one bank (byte addresses)
  localparam logic [7:0] OFS_MASKED = 8'h00;
  localparam logic [7:0] OFS_RAW    = 8'h04;
  localparam logic [7:0] OFS_EN_SET = 8'h08;
  localparam logic [7:0] OFS_EN_CLR = 8'h0C;
  localparam logic [7:0] OFS_NUM    = 8'h24;

  typedef enum logic [2:0] {
    REG_MASKED,
    REG_RAW,
    REG_EN_SET,
    REG_EN_CLR,
    REG_NUM,
    REG_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_MASKED: decode_ofs = REG_MASKED;
      OFS_RAW:    decode_ofs = REG_RAW;
      OFS_EN_SET: decode_ofs = REG_EN_SET;
      OFS_EN_CLR: decode_ofs = REG_EN_CLR;
      OFS_NUM:    decode_ofs = REG_NUM;
      default:    decode_ofs = REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bic_edge_capture.sv
module bic_edge_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;

endmodule

// File: rtl/bic_lowest_set.sv
module bic_lowest_set #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o
);

  // Scan from the top so the lowest set bit is assigned last
  always_comb begin
    idx_o = IDX_W'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/bic_bank.sv
module bic_bank #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     rise_i,
  input  logic             ack_we_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [N-1:0]     wdata_i,
  output logic [N-1:0]     raw_o,
  output logic [N-1:0]     en_o,
  output logic [N-1:0]     masked_o,
  output logic [IDX_W-1:0] num_o,
  output logic             req_o
);

  localparam logic [IDX_W-1:0] NONE = IDX_W'(N);

  logic [N-1:0] raw_q, raw_d, en_q, en_d;
  logic         raw_ce, en_ce;

  // Next state: a new edge wins over an acknowledge of the same bit
  always_comb begin
    raw_ce = ack_we_i | (|rise_i);
    raw_d  = ack_we_i ? ((raw_q & ~wdata_i) | rise_i) : (raw_q | rise_i);
    en_ce  = set_we_i | clr_we_i;
    en_d   = en_q;
    if (set_we_i) en_d = en_q | wdata_i;
    if (clr_we_i) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      if (raw_ce) raw_q <= raw_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;
  assign req_o    = |masked_o;

  bic_lowest_set #(.N(N), .IDX_W(IDX_W)) u_lowest (
    .vec_i (masked_o),
    .idx_o (num_o)
  );

  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((raw_q & $past(rise_i)) == $past(rise_i)));

  p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we_i |=> ((raw_q & $past(wdata_i & ~rise_i)) == '0));

  p_edge_beats_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && ((wdata_i & rise_i) != '0)) |=>
      ((raw_q & $past(wdata_i & rise_i)) == $past(wdata_i & rise_i)));

  p_set_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  p_clr_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((en_q & $past(wdata_i)) == '0));

  p_num_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((num_o < NONE) && (((masked_o >> num_o) & N'(1)) != '0)));

  p_num_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (num_o == NONE));

endmodule

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] raw_w    [NBANK];
  logic [NUM_SRC-1:0] en_w     [NBANK];
  logic [NUM_SRC-1:0] masked_w [NBANK];
  logic [IDX_W-1:0]   num_w    [NBANK];
  logic [NBANK-1:0]   req_w;

  reg_sel_e   sel;
  logic       bank;
  logic       mapped;
  logic [BUS_W-1:0] rd_val, rdata_q;

  // Address decode: bit 8 picks the bank, bits above 8 must be zero
  always_comb begin
    sel    = decode_ofs(bus_addr[7:0]);
    bank   = bus_addr[8];
    mapped = (bus_addr[ADDR_W-1:9] == '0) && (sel != REG_NONE);
  end

  bic_edge_capture #(.N(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .rise_o (rise)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && mapped && (bank == 1'(b));

    bic_bank #(.N(NUM_SRC), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise),
      .ack_we_i (hit && (sel == REG_RAW)),
      .set_we_i (hit && (sel == REG_EN_SET)),
      .clr_we_i (hit && (sel == REG_EN_CLR)),
      .wdata_i  (bus_wdata[NUM_SRC-1:0]),
      .raw_o    (raw_w[b]),
      .en_o     (en_w[b]),
      .masked_o (masked_w[b]),
      .num_o    (num_w[b]),
      .req_o    (req_w[b])
    );
  end

  always_comb begin
    rd_val = '0;
    if (mapped) begin
      case (sel)
        REG_MASKED: rd_val = BUS_W'(masked_w[bank]);
        REG_RAW:    rd_val = BUS_W'(raw_w[bank]);
        REG_EN_SET,
        REG_EN_CLR: rd_val = BUS_W'(en_w[bank]);
        REG_NUM:    rd_val = BUS_W'(num_w[bank]);
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = req_w[0];
  assign fiq_o     = req_w[1];

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/bic_ctrl_bench.sv
module bic_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic rd_seen;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  bic_ctrl u_bic_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rst_n && rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R11 unexpected read data actual %h expected none", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk({31'b0, irq_o}, 32'd0, "R10 irq_o after reset");
    chk({31'b0, fiq_o}, 32'd0, "R10 fiq_o after reset");
    bus_read(12'h004, 32'h0, "R10 raw after reset");
    bus_read(12'h008, 32'h0, "R10 enable after reset");
    bus_read(12'h024, 32'd32, "R10 bank0 number after reset");
    bus_read(12'h124, 32'd32, "R10 bank1 number after reset");

    // R1 edge capture on lines 5 and 31, both banks
    @(negedge clk); src[5] = 1'b1; src[31] = 1'b1;
    bus_read(12'h004, 32'h8000_0020, "R1 raw after edges");
    bus_read(12'h104, 32'h8000_0020, "R8 bank1 raw after edges");
    bus_read(12'h000, 32'h0, "R6 masked with nothing enabled");
    chk({31'b0, irq_o}, 32'd0, "R6 irq_o low with no enables");

    // R4 / R5 / R6 / R7 enable handling
    bus_write(12'h008, 32'h8000_0000);
    bus_read(12'h008, 32'h8000_0000, "R4 enable readback");
    bus_read(12'h00C, 32'h8000_0000, "R5 disable address mirrors enable");
    bus_read(12'h000, 32'h8000_0000, "R6 masked status");
    chk({31'b0, irq_o}, 32'd1, "R6 irq_o high");
    chk({31'b0, fiq_o}, 32'd0, "R8 fiq_o stays low");
    bus_read(12'h024, 32'd31, "R7 number top line");
    bus_write(12'h008, 32'h0000_0020);
    bus_read(12'h008, 32'h8000_0020, "R4 set keeps other bits");
    bus_read(12'h024, 32'd5, "R7 lowest line wins");
    bus_write(12'h00C, 32'h0000_0020);
    bus_read(12'h00C, 32'h8000_0000, "R5 clear one enable");
    bus_read(12'h024, 32'd31, "R7 number after disable");

    // R2 acknowledge; line 5 held high must not re-set (R1)
    bus_write(12'h004, 32'h0000_0020);
    bus_read(12'h004, 32'h8000_0000, "R2 ack clears only bit 5, R1 no re-set");
    bus_read(12'h104, 32'h8000_0020, "R8 bank1 raw untouched by bank0 ack");
    bus_write(12'h004, 32'h8000_0000);
    bus_read(12'h004, 32'h0, "R2 ack clears bit 31");
    chk({31'b0, irq_o}, 32'd0, "R6 irq_o low after ack");
    bus_read(12'h024, 32'd32, "R7 number when nothing pending");

    // R3 edge and acknowledge in the same cycle
    @(negedge clk); src[31] = 1'b0;
    @(negedge clk);
    src[31] = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h8000_0000; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    bus_read(12'h004, 32'h8000_0000, "R3 edge beats ack");

    // R9 unmapped and read-only addresses
    bus_write(12'h010, 32'hFFFF_FFFF);
    bus_write(12'h208, 32'hFFFF_FFFF);
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h024, 32'hFFFF_FFFF);
    bus_read(12'h008, 32'h8000_0000, "R9 bank0 enable unchanged");
    bus_read(12'h108, 32'h0, "R9 bank1 enable unchanged");
    bus_read(12'h004, 32'h8000_0000, "R9 bank0 raw unchanged");
    bus_read(12'h010, 32'h0, "R9 unmapped offset reads zero");
    bus_read(12'h208, 32'h0, "R9 address above banks reads zero");

    // R8 bank 1 operation
    bus_write(12'h108, 32'h0000_0001);
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk);
    chk({31'b0, fiq_o}, 32'd1, "R8 fiq_o high");
    bus_read(12'h124, 32'd0, "R8 bank1 number");
    bus_read(12'h100, 32'h0000_0001, "R8 bank1 masked");
    bus_read(12'h024, 32'd31, "R8 bank0 number independent");
    bus_write(12'h104, 32'hFFFF_FFFF);
    chk({31'b0, fiq_o}, 32'd0, "R8 fiq_o low after ack");
    bus_read(12'h104, 32'h0, "R8 bank1 raw cleared");
    bus_read(12'h124, 32'd32, "R8 bank1 number none");
    bus_read(12'h004, 32'h8000_0001, "R8 bank0 raw kept");
    chk({31'b0, irq_o}, 32'd1, "R8 irq_o still high");

    // R11 read data holds while bus_rd is low
    repeat (3) @(negedge clk);
    chk(bus_rdata, 32'h8000_0001, "R11 read data held");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 reads without data actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule